// File: doc/BRIEF.md
# Relaxed-Alignment Access Span Checker

This block sits on the load/store path and judges every memory access before it goes any further. The core presents an effective address, a size code, a direction flag and a flag that marks a capability access. One clock later the block returns whether the access may proceed and, if it may not, which address-error kind should be raised. Raising the exception is left to the surrounding pipeline.

Ordinary loads and stores do not have to be naturally aligned. An ordinary access is refused only when its bytes would straddle a boundary between two 16-byte granules. Capability accesses keep the strict rule: the address must be a multiple of the access size. The sum that locates the last byte carries one extra bit. An access that wraps past the top of the address space therefore counts as a crossing.

Top module: `acc_span_checker`

## Requirements
- R1: The size code `acc_size` encodes the byte count: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes.
- R2: An ordinary access (`acc_cap`=0) is permitted exactly when its first and last byte addresses, divided by 16, give the same unsigned quotient.
- R3: An ordinary 1-byte access is always permitted, whatever its address.
- R4: A capability access (`acc_cap`=1) is permitted exactly when the address is a multiple of the access size.
- R5: `res_code` is 0 for a permitted access. A refused load is reported as 4 and a refused store (`acc_store`=1) as 5.
- R6: The address of the last byte is formed with a carry bit. An ordinary multi-byte access that runs past address 2^64−1 is refused.
- R7: `res_valid` is high in the cycle after `acc_valid` is high and low otherwise. When `acc_valid` is low, `res_ok` and `res_code` keep their previous values.
- R8: While reset is asserted and just after it: `res_valid`=0, `res_ok`=1, `res_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 64 | Effective byte address |
| acc_size | input | 2 | Size code (R1) |
| acc_store | input | 1 | 1 for a store, 0 for a load or fetch |
| acc_cap | input | 1 | 1 for a capability access |
| res_valid | output | 1 | A verdict is presented |
| res_ok | output | 1 | 1 when the access is permitted |
| res_code | output | 5 | Address-error kind, 0 when permitted (R5) |

## Verification
The assertions assume that every input is a known value whenever `acc_valid` is high. They also assume that a verdict depends only on the access presented in the cycle before. The stimulus is driven on the falling edge and is always fully defined. Directed cases probe each side of a granule edge for every size, and the top of the address space. Random addresses, with their low nibble spread across all sixteen offsets, are interleaved with idle cycles to cover the hold behaviour.

// File: rtl/acc_span_pkg.sv
package acc_span_pkg;
  localparam int ADDR_W   = 64;
  localparam int CODE_W   = 5;
  localparam int SZ_W     = 2;
  localparam int MAX_LOG  = (1 << SZ_W) - 1;
  localparam int BYTES_W  = MAX_LOG + 1;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam logic [CODE_W-1:0] CODE_NONE  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_LOAD  = 5'd4;
  localparam logic [CODE_W-1:0] CODE_STORE = 5'd5;
endpackage

// File: rtl/acc_size_decode.sv
module acc_size_decode
  import acc_span_pkg::*;
#(
  parameter int SIZE_W = SZ_W,
  localparam int BW    = (1 << SIZE_W)
) (
  input  logic [SIZE_W-1:0] size_code,
  output logic [BW-1:0]     nbytes,
  output logic [BW-1:0]     nbytes_m1
);
  // R1: the byte count is two raised to the size code
  generate
    for (genvar k = 0; k < BW; k++) begin : g_bit
      assign nbytes[k] = (size_code == SIZE_W'(k));
    end
  endgenerate
  assign nbytes_m1 = nbytes - BW'(1);
endmodule

// File: rtl/acc_granule_cross.sv
module acc_granule_cross #(
  parameter int AW       = 64,
  parameter int GRAN_LOG = 4,
  parameter int OFF_W    = 4
) (
  input  logic [AW-1:0]    addr,
  input  logic [OFF_W-1:0] span_m1,
  output logic             crosses
);
  logic [AW:0] last_byte;
  logic [AW:0] first_ext;

  // R6: the extra top bit keeps the carry out of the address
  assign first_ext = {1'b0, addr};
  assign last_byte = first_ext + (AW+1)'(span_m1);
  // R2: compare the granule index of the first and the last byte
  assign crosses   = (last_byte[AW:GRAN_LOG] != first_ext[AW:GRAN_LOG]);
endmodule

// File: rtl/acc_natural_align.sv
module acc_natural_align #(
  parameter int AW    = 64,
  parameter int OFF_W = 4
) (
  input  logic [AW-1:0]    addr,
  input  logic [OFF_W-1:0] span_m1,
  output logic             misaligned
);
  logic [OFF_W-1:0] hit;
  // R4: any low address bit under the size mask makes the access misaligned
  generate
    for (genvar k = 0; k < OFF_W; k++) begin : g_mask
      assign hit[k] = addr[k] & span_m1[k];
    end
  endgenerate
  assign misaligned = |hit;
endmodule

// File: rtl/acc_span_checker.sv
module acc_span_checker
  import acc_span_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int GRAN_BYTES = 16,
  localparam int GRAN_LOG  = $clog2(GRAN_BYTES),
  localparam int BW        = BYTES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [SZ_W-1:0]   acc_size,
  input  logic              acc_store,
  input  logic              acc_cap,
  output logic              res_valid,
  output logic              res_ok,
  output logic [CODE_W-1:0] res_code
);
  logic [BW-1:0]     nbytes;
  logic [BW-1:0]     span_m1;
  logic              crosses;
  logic              misaligned;
  logic              ok_d;
  logic [CODE_W-1:0] code_d;

  acc_size_decode #(.SIZE_W(SZ_W)) u_dec (
    .size_code (acc_size),
    .nbytes    (nbytes),
    .nbytes_m1 (span_m1)
  );

  acc_granule_cross #(.AW(AW), .GRAN_LOG(GRAN_LOG), .OFF_W(BW)) u_cross (
    .addr    (acc_addr),
    .span_m1 (span_m1),
    .crosses (crosses)
  );

  acc_natural_align #(.AW(AW), .OFF_W(BW)) u_align (
    .addr       (acc_addr),
    .span_m1    (span_m1),
    .misaligned (misaligned)
  );

  always_comb begin
    ok_d   = acc_cap ? !misaligned : !crosses;
    code_d = ok_d ? CODE_NONE : (acc_store ? CODE_STORE : CODE_LOAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b1;
      res_code  <= CODE_NONE;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_ok   <= ok_d;
        res_code <= code_d;
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);
  // R7
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ($stable(res_ok) && $stable(res_code)));
  // R3
  byte_never_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_cap && acc_size == SZ_BYTE) |=> res_ok);
  // R4
  cap_odd_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_cap && acc_addr[0] && acc_size != SZ_BYTE) |=> !res_ok);
  // R5
  ok_code_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ok) |-> (res_code == CODE_NONE));
  // R5
  store_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_store) |=> (res_ok || res_code == CODE_STORE));
  // R5
  load_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_store) |=> (res_ok || res_code == CODE_LOAD));
endmodule

// File: tb/test_acc_span_checker.sv
module test_acc_span_checker;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid;
  logic [63:0] acc_addr;
  logic [1:0]  acc_size;
  logic        acc_store;
  logic        acc_cap;
  logic        res_valid;
  logic        res_ok;
  logic [4:0]  res_code;

  int checks = 0;
  int errors = 0;
  logic        e_valid = 1'b0;
  logic        e_ok = 1'b1;
  logic [4:0]  e_code = 5'd0;
  string       e_tag = "R8";

  always #2.5 clk = ~clk;

  acc_span_checker i_acc_span_checker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_store(acc_store), .acc_cap(acc_cap),
    .res_valid(res_valid), .res_ok(res_ok), .res_code(res_code)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: integer byte count, division by the granule size.
  task automatic model(input logic v, input logic [63:0] a, input logic [1:0] sz,
                       input logic st, input logic cp);
    logic [64:0] first;
    logic [64:0] last;
    int          n;
    logic        okv;
    n     = 1;
    for (int i = 0; i < int'(sz); i++) n = n * 2;  // R1
    first = {1'b0, a};
    last  = first + 65'(n) - 65'd1;
    if (cp) okv = ((first % 65'(n)) == 0);          // R4
    else    okv = ((first / 65'd16) == (last / 65'd16)); // R2, R6
    e_valid = v;
    if (v) begin
      e_ok   = okv;
      e_code = okv ? 5'd0 : (st ? 5'd5 : 5'd4);
      if (cp)                 e_tag = "R4";
      else if (sz == 2'd0)    e_tag = "R3";
      else if (last[64])      e_tag = "R6";
      else                    e_tag = "R1/R2";
    end else begin
      e_tag = "R7";
    end
  endtask

  task automatic step(input logic v, input logic [63:0] a, input logic [1:0] sz,
                      input logic st, input logic cp);
    @(negedge clk);
    chk("R7 valid", longint'(res_valid), longint'(e_valid));
    chk({e_tag, " ok"}, longint'(res_ok), longint'(e_ok));
    chk("R5 code", longint'(res_code), longint'(e_code));
    acc_valid = v; acc_addr = a; acc_size = sz; acc_store = st; acc_cap = cp;
    model(v, a, sz, st, cp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_addr = '0; acc_size = '0;
    acc_store = 1'b0; acc_cap = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset values
    chk("R8 valid", longint'(res_valid), 0);
    chk("R8 ok", longint'(res_ok), 1);
    chk("R8 code", longint'(res_code), 0);
    rst = 1'b0;

    step(1, 64'h0, 2'd3, 0, 0);          // R2 aligned dword
    step(1, 64'h8, 2'd3, 0, 0);          // R2 dword ends at granule edge
    step(1, 64'h9, 2'd3, 0, 0);          // R2 crossing load, R5 code 4
    step(1, 64'h9, 2'd3, 1, 0);          // R5 crossing store, code 5
    step(1, 64'h1F, 2'd1, 0, 0);         // R1 half crossing
    step(1, 64'h1E, 2'd1, 1, 0);         // R1 half inside
    step(1, 64'h2C, 2'd2, 0, 0);         // R1 word ends at edge
    step(1, 64'h2D, 2'd2, 1, 0);         // R1 word crossing
    step(1, 64'h3, 2'd2, 0, 0);          // R2 unaligned word inside granule
    step(1, 64'h0F, 2'd0, 1, 0);         // R3 byte at last offset
    step(0, 64'h9, 2'd3, 0, 0);          // R7 idle holds previous verdict
    step(0, 64'h0, 2'd0, 0, 0);          // R7 idle again
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 0, 0); // R6 wrap half
    step(1, 64'hFFFF_FFFF_FFFF_FFF9, 2'd3, 1, 0); // R6 wrap dword
    step(1, 64'hFFFF_FFFF_FFFF_FFF8, 2'd3, 0, 0); // R6 top dword fits
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 0); // R3 byte at top
    step(1, 64'h4, 2'd2, 0, 1);          // R4 aligned cap word
    step(1, 64'h2, 2'd2, 0, 1);          // R4 cap word misaligned, no crossing
    step(1, 64'h8, 2'd3, 1, 1);          // R4 aligned cap dword
    step(1, 64'h1, 2'd1, 1, 1);          // R4 cap half odd, store code 5
    step(1, 64'h7, 2'd0, 0, 1);          // R4 cap byte
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra;
      ra = {$urandom, $urandom};
      step(($urandom % 4) != 0, ra, 2'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end
    step(0, 64'h0, 2'd0, 0, 0);
    step(0, 64'h0, 2'd0, 0, 0);
    finish_run();
  end
endmodule